// File: doc/BRIEF.md
# Dual Wiper Position Register Bank

This block keeps the wiper position of two resistor-ladder channels. Each channel owns one volatile 6-bit position register and four retained 6-bit stored settings. A bus decoder in front of it hands over one command at a time on a valid/ready port. A command can load a position directly, step it one tap up or down, copy a stored setting into the position, copy the position into a stored setting, or write host data into a stored setting. The copy commands can target one channel or both channels at once. Each position is decoded onto 64 one-hot tap-enable lines that drive the switch array.

Back-pressure rules: a command transfers on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. The decoder must hold `cmd_valid` and the command fields steady until that edge. The bank lowers `cmd_ready` in two cases. It stays low from a setting-to-position copy until the bus stop strobe applies the copy. It also stays low from any write into stored settings until the write-timer completion strobe commits that write. Reads of state go through a plain combinational port and do not take part in the handshake.

Two resets are used. `por_n` models the first application of power and gives the stored settings their initial contents. `rst_n` clears the volatile state and reloads each position from that channel's setting 0.

Top module: `wiper_bank`

## Requirements
- R1: After reset, each channel's 64-bit tap group has exactly one line high, and that line's index equals the channel's position value. Index 0 is the low end of the ladder and index 63 is the high end.
- R2: While `por_n` is low, setting i of channel c holds (7*(4*c+i)+3) mod 64. A clock edge with `rst_n` low loads each position from setting 0 of its channel. Stored settings keep their values through `rst_n`.
- R3: An accepted command with op 0 (load) sets the position of channel `cmd_chan` to `cmd_data` at that edge.
- R4: Op 6 (up) raises the selected position by one and op 7 (down) lowers it by one. Up at 63 leaves 63, and down at 0 leaves 0.
- R5: Op 1 (fetch) captures setting `cmd_idx` of channel `cmd_chan`. The position does not change until the first clock edge at which `bus_stop` is high. It changes at that edge.
- R6: Op 2 (fetch all) does the same as op 1 for both channels with the same `cmd_idx`. Both positions change at the same stop edge.
- R7: Op 3 (save) captures the position of the selected channel, op 4 (save all) captures both positions, and op 5 (store) captures `cmd_data`. Each goes into setting `cmd_idx`. The write commits only at the edge where `wr_done` is high. Until then, reads return the old value. A `wr_done` with nothing pending changes nothing.
- R8: `cmd_ready` is high exactly when no fetch awaits a stop and no write awaits completion. A command is taken only at an edge with both `cmd_valid` and `cmd_ready` high.
- R9: `rd_data` shows the position of channel `rd_chan` when `rd_wcr` is high. Otherwise it shows that channel's setting `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Volatile reset, low active, synchronous recall of setting 0 |
| por_n | input | 1 | Power-on reset of stored settings, low active |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Bank can take a command |
| cmd_op | input | 3 | Operation code (see R3 to R7) |
| cmd_chan | input | 1 | Target channel |
| cmd_idx | input | 2 | Stored setting index |
| cmd_data | input | 6 | Position or setting value |
| bus_stop | input | 1 | Stop strobe from the bus decoder |
| wr_done | input | 1 | Write completion strobe from the write timer |
| rd_chan | input | 1 | Read channel |
| rd_wcr | input | 1 | Read the position instead of a setting |
| rd_idx | input | 2 | Read setting index |
| rd_data | output | 6 | Read value |
| tap_o | output | 128 | One-hot tap enables, channel c on bits c*64 to c*64+63 |

## Verification
The hardest situations to reach are the windows in which a command is held back. One window is a fetch captured but not yet applied. The other is a stored-setting write accepted but not yet committed. In both, the position, the read port and the handshake must all show the old state. The stimulus opens each window on purpose. It holds the stop strobe or the completion strobe off for several idle cycles. During that time it reads the affected setting and offers a further command so that back-pressure has to act. A reference model compares every port on every clock. It runs alongside directed checks of saturation at both ends, a completion strobe with nothing pending, and settings kept across a volatile reset.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [2:0] {
    OP_LOAD      = 3'd0,
    OP_FETCH     = 3'd1,
    OP_FETCH_ALL = 3'd2,
    OP_SAVE      = 3'd3,
    OP_SAVE_ALL  = 3'd4,
    OP_STORE     = 3'd5,
    OP_UP        = 3'd6,
    OP_DOWN      = 3'd7
  } wop_e;
endpackage

// File: rtl/wiper_decode.sv
module wiper_decode #(
  parameter int W = 6,
  localparam int TAPS = 1 << W
) (
  input  logic [W-1:0]    pos,
  output logic [TAPS-1:0] tap
);
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign tap[k] = (pos == W'(k));
  end
endmodule

// File: rtl/wiper_chan.sv
module wiper_chan #(
  parameter int W   = 6,
  parameter int NDR = 4,
  parameter int CH  = 0,
  localparam int IW   = (NDR > 1) ? $clog2(NDR) : 1,
  localparam int TAPS = 1 << W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  por_n,
  input  logic                  ld_en,
  input  logic [W-1:0]          ld_val,
  input  logic                  up_en,
  input  logic                  dn_en,
  input  logic                  dr_we,
  input  logic [IW-1:0]         dr_idx,
  input  logic [W-1:0]          dr_val,
  output logic [W-1:0]          wcr_o,
  output logic [NDR-1:0][W-1:0] drs_o,
  output logic [TAPS-1:0]       tap_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [NDR-1:0][W-1:0] dr;
  logic [W-1:0]          wcr;

  function automatic logic [W-1:0] init_val(input int i);
    int v;
    v = (7 * (NDR * CH + i) + 3) % TAPS;
    return v[W-1:0];
  endfunction

  // retained settings: only the power-on reset touches them
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < NDR; i++) dr[i] <= init_val(i);
    end else if (dr_we) begin
      dr[dr_idx] <= dr_val;
    end
  end

  // volatile position: synchronous recall of setting 0
  always_ff @(posedge clk) begin
    if (!rst_n)                    wcr <= dr[0];
    else if (ld_en)                wcr <= ld_val;
    else if (up_en && wcr != TOP)  wcr <= wcr + W'(1);
    else if (dn_en && wcr != '0)   wcr <= wcr - W'(1);
  end

  assign wcr_o = wcr;
  assign drs_o = dr;

  wiper_decode #(.W(W)) u_dec (.pos(wcr), .tap(tap_o));
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int W   = 6,
  parameter int NDR = 4,
  parameter int NCH = 2,
  localparam int IW = (NDR > 1) ? $clog2(NDR) : 1,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_valid,
  output logic                           cmd_ready,
  input  wop_e                           cmd_op,
  input  logic [CW-1:0]                  cmd_chan,
  input  logic [IW-1:0]                  cmd_idx,
  input  logic [W-1:0]                   cmd_data,
  input  logic                           bus_stop,
  input  logic                           wr_done,
  input  logic [NCH-1:0][W-1:0]          wcr_i,
  input  logic [NCH-1:0][NDR-1:0][W-1:0] drs_i,
  output logic [NCH-1:0]                 ld_en,
  output logic [NCH-1:0][W-1:0]          ld_val,
  output logic [NCH-1:0]                 up_en,
  output logic [NCH-1:0]                 dn_en,
  output logic [NCH-1:0]                 dr_we,
  output logic [IW-1:0]                  dr_idx,
  output logic [NCH-1:0][W-1:0]          dr_val
);
  logic                  stg_v, pnd_v;
  logic [NCH-1:0]        stg_mask, pnd_mask, sel;
  logic [NCH-1:0][W-1:0] stg_val, pnd_val;
  logic [IW-1:0]         pnd_idx;
  logic                  accept, apply;

  assign cmd_ready = !stg_v && !pnd_v;
  assign accept    = cmd_valid && cmd_ready;
  assign apply     = stg_v && bus_stop;

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign sel[c] = (cmd_chan == CW'(c));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_v <= 1'b0; pnd_v <= 1'b0;
      stg_mask <= '0; pnd_mask <= '0;
      stg_val <= '0; pnd_val <= '0; pnd_idx <= '0;
    end else begin
      if (apply)            stg_v <= 1'b0;
      if (pnd_v && wr_done) pnd_v <= 1'b0;
      if (accept) begin
        unique case (cmd_op)
          OP_FETCH, OP_FETCH_ALL: begin
            stg_v    <= 1'b1;
            stg_mask <= (cmd_op == OP_FETCH_ALL) ? '1 : sel;
            for (int c = 0; c < NCH; c++) stg_val[c] <= drs_i[c][cmd_idx];
          end
          OP_SAVE, OP_SAVE_ALL, OP_STORE: begin
            pnd_v    <= 1'b1;
            pnd_mask <= (cmd_op == OP_SAVE_ALL) ? '1 : sel;
            pnd_idx  <= cmd_idx;
            for (int c = 0; c < NCH; c++)
              pnd_val[c] <= (cmd_op == OP_STORE) ? cmd_data : wcr_i[c];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      ld_en[c]  = (accept && cmd_op == OP_LOAD && sel[c]) || (apply && stg_mask[c]);
      ld_val[c] = apply ? stg_val[c] : cmd_data;
      up_en[c]  = accept && cmd_op == OP_UP && sel[c];
      dn_en[c]  = accept && cmd_op == OP_DOWN && sel[c];
      dr_we[c]  = pnd_v && wr_done && pnd_mask[c];
      dr_val[c] = pnd_val[c];
    end
    dr_idx = pnd_idx;
  end
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wiper_pkg::*;
#(
  parameter int W   = 6,
  parameter int NDR = 4,
  parameter int NCH = 2,
  localparam int IW   = (NDR > 1) ? $clog2(NDR) : 1,
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int TAPS = 1 << W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  por_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [2:0]            cmd_op,
  input  logic [CW-1:0]         cmd_chan,
  input  logic [IW-1:0]         cmd_idx,
  input  logic [W-1:0]          cmd_data,
  input  logic                  bus_stop,
  input  logic                  wr_done,
  input  logic [CW-1:0]         rd_chan,
  input  logic                  rd_wcr,
  input  logic [IW-1:0]         rd_idx,
  output logic [W-1:0]          rd_data,
  output logic [NCH*TAPS-1:0]   tap_o
);
  logic [NCH-1:0][W-1:0]          wcr, ld_val, dr_val;
  logic [NCH-1:0][NDR-1:0][W-1:0] drs;
  logic [NCH-1:0]                 ld_en, up_en, dn_en, dr_we;
  logic [IW-1:0]                  dr_idx;

  wiper_ctrl #(.W(W), .NDR(NDR), .NCH(NCH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(wop_e'(cmd_op)),
    .cmd_chan(cmd_chan), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
    .bus_stop(bus_stop), .wr_done(wr_done),
    .wcr_i(wcr), .drs_i(drs),
    .ld_en(ld_en), .ld_val(ld_val), .up_en(up_en), .dn_en(dn_en),
    .dr_we(dr_we), .dr_idx(dr_idx), .dr_val(dr_val)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    wiper_chan #(.W(W), .NDR(NDR), .CH(c)) u_chan (
      .clk(clk), .rst_n(rst_n), .por_n(por_n),
      .ld_en(ld_en[c]), .ld_val(ld_val[c]),
      .up_en(up_en[c]), .dn_en(dn_en[c]),
      .dr_we(dr_we[c]), .dr_idx(dr_idx), .dr_val(dr_val[c]),
      .wcr_o(wcr[c]), .drs_o(drs[c]),
      .tap_o(tap_o[c*TAPS +: TAPS])
    );
  end

  assign rd_data = rd_wcr ? wcr[rd_chan] : drs[rd_chan][rd_idx];
endmodule

// File: rtl/wiper_bank_chk.sv
module wiper_bank_chk #(
  parameter int W   = 6,
  parameter int NDR = 4,
  parameter int NCH = 2,
  localparam int IW   = (NDR > 1) ? $clog2(NDR) : 1,
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int TAPS = 1 << W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic [2:0]          cmd_op,
  input logic [CW-1:0]       cmd_chan,
  input logic                bus_stop,
  input logic                wr_done,
  input logic [NCH*TAPS-1:0] tap_o
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  for (genvar c = 0; c < NCH; c++) begin : g_c
    a_r1_single_tap: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap_o[c*TAPS +: TAPS]) == 1);
    a_r4_top_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == 3'd6 && cmd_chan == CW'(c) && tap_o[c*TAPS + TAPS-1])
      |=> tap_o[c*TAPS + TAPS-1]);
    a_r4_bottom_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == 3'd7 && cmd_chan == CW'(c) && tap_o[c*TAPS])
      |=> tap_o[c*TAPS]);
  end

  a_r5_fetch_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd_op == 3'd1 || cmd_op == 3'd2)) |=> $stable(tap_o));
  a_r7_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd_op == 3'd3 || cmd_op == 3'd4 || cmd_op == 3'd5)) |=> !cmd_ready);
  a_r8_ready_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && !bus_stop && !wr_done) |=> !cmd_ready);
endmodule

bind wiper_bank wiper_bank_chk #(.W(W), .NDR(NDR), .NCH(NCH)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_chan(cmd_chan), .bus_stop(bus_stop),
  .wr_done(wr_done), .tap_o(tap_o)
);

// File: tb/test_wiper_bank.sv
module test_wiper_bank;
  logic clk = 0, rst_n = 0, por_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [2:0] cmd_op = 0;
  logic cmd_chan = 0;
  logic [1:0] cmd_idx = 0;
  logic [5:0] cmd_data = 0;
  logic bus_stop = 0, wr_done = 0;
  logic rd_chan = 0, rd_wcr = 1;
  logic [1:0] rd_idx = 0;
  logic [5:0] rd_data;
  logic [127:0] tap_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wiper_bank i_wiper_bank (.*);

  // behavioural reference model
  int m_wcr[2];
  int m_dr[2][4];
  bit s_v, p_v;
  int s_val[2], p_val[2];
  bit s_m[2], p_m[2];
  int p_idx;

  always @(posedge clk) begin
    bit acc;
    if (!por_n)
      for (int c = 0; c < 2; c++) for (int i = 0; i < 4; i++) m_dr[c][i] = (7*(4*c+i)+3) % 64;
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) m_wcr[c] = m_dr[c][0];
      s_v = 0; p_v = 0;
    end else begin
      acc = cmd_valid && !s_v && !p_v;
      if (s_v && bus_stop) begin
        for (int c = 0; c < 2; c++) if (s_m[c]) m_wcr[c] = s_val[c];
        s_v = 0;
      end
      if (p_v && wr_done) begin
        for (int c = 0; c < 2; c++) if (p_m[c]) m_dr[c][p_idx] = p_val[c];
        p_v = 0;
      end
      if (acc) begin
        for (int c = 0; c < 2; c++) begin
          bit hit;
          hit = (c == int'(cmd_chan));
          case (cmd_op)
            3'd0: if (hit) m_wcr[c] = cmd_data;
            3'd1, 3'd2: begin s_v = 1; s_m[c] = hit || cmd_op == 3'd2; s_val[c] = m_dr[c][cmd_idx]; end
            3'd3, 3'd4, 3'd5: begin
              p_v = 1; p_m[c] = hit || cmd_op == 3'd4; p_idx = cmd_idx;
              p_val[c] = (cmd_op == 3'd5) ? int'(cmd_data) : m_wcr[c];
            end
            3'd6: if (hit && m_wcr[c] < 63) m_wcr[c]++;
            default: if (hit && m_wcr[c] > 0) m_wcr[c]--;
          endcase
        end
      end
    end
  end

  // per-clock comparison against the model (R1, R8, R9)
  always @(negedge clk) begin
    if (rst_n && por_n && !finished) begin
      int exp_rd;
      for (int c = 0; c < 2; c++) begin
        logic [63:0] e;
        e = 64'd1 << m_wcr[c];
        n_chk++;
        if (tap_o[c*64 +: 64] !== e) begin
          n_fail++;
          $display("FAIL R1 ch%0d taps act=%h exp=%h", c, tap_o[c*64 +: 64], e);
        end
      end
      n_chk++;
      if (cmd_ready !== (!s_v && !p_v)) begin
        n_fail++;
        $display("FAIL R8 ready act=%b exp=%b", cmd_ready, !s_v && !p_v);
      end
      exp_rd = rd_wcr ? m_wcr[rd_chan] : m_dr[rd_chan][rd_idx];
      n_chk++;
      if (int'(rd_data) != exp_rd) begin
        n_fail++;
        $display("FAIL R9 rd act=%0d exp=%0d", rd_data, exp_rd);
      end
    end
  end

  task automatic send(input int op, input int ch, input int idx, input int d);
    @(negedge clk); #1;
    cmd_valid = 1; cmd_op = 3'(op); cmd_chan = ch[0]; cmd_idx = 2'(idx); cmd_data = 6'(d);
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic strobe_stop();
    @(negedge clk); #1; bus_stop = 1; @(posedge clk); #1; bus_stop = 0;
  endtask

  task automatic strobe_done();
    @(negedge clk); #1; wr_done = 1; @(posedge clk); #1; wr_done = 0;
  endtask

  // directed check through the read port; wcr=1 reads position
  task automatic expect_rd(input int ch, input bit wcr, input int idx, input int exp, input string tag);
    @(negedge clk); #1;
    rd_chan = ch[0]; rd_wcr = wcr; rd_idx = 2'(idx);
    @(negedge clk);
    n_chk++;
    if (int'(rd_data) != exp) begin
      n_fail++;
      $display("FAIL %s ch%0d %s%0d act=%0d exp=%0d", tag, ch, wcr ? "pos" : "set", idx, rd_data, exp);
    end
  endtask

  task automatic expect_ready(input bit exp, input string tag);
    @(negedge clk);
    n_chk++;
    if (cmd_ready !== exp) begin
      n_fail++;
      $display("FAIL %s ready act=%b exp=%b", tag, cmd_ready, exp);
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    por_n = 1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R2: recall and initial settings
    expect_rd(0, 1, 0, 3, "R2");
    expect_rd(1, 1, 0, 31, "R2");
    expect_rd(1, 0, 2, 45, "R2");
    // R3 direct load
    send(0, 0, 0, 60);
    expect_rd(0, 1, 0, 60, "R3");
    // R4 saturate high and low
    for (int k = 0; k < 5; k++) send(6, 0, 0, 0);
    expect_rd(0, 1, 0, 63, "R4");
    for (int k = 0; k < 40; k++) send(7, 1, 0, 0);
    expect_rd(1, 1, 0, 0, "R4");
    // R7 store waits for completion, old value readable meanwhile
    send(5, 0, 1, 33);
    expect_ready(0, "R7");
    expect_rd(0, 0, 1, 10, "R7");
    fork
      send(6, 1, 0, 0);            // R8: held off until completion
      begin repeat (3) @(negedge clk); strobe_done(); end
    join
    expect_rd(0, 0, 1, 33, "R7");
    expect_rd(1, 1, 0, 1, "R8");
    // R7 stray completion is ignored
    strobe_done();
    expect_rd(0, 0, 1, 33, "R7");
    expect_ready(1, "R7");
    // R5 fetch waits for stop
    send(1, 0, 1, 0);
    repeat (3) @(negedge clk);
    expect_rd(0, 1, 0, 63, "R5");
    expect_ready(0, "R5");
    strobe_stop();
    expect_rd(0, 1, 0, 33, "R5");
    // R7 save position of ch1 into setting 3
    send(3, 1, 3, 0);
    strobe_done();
    expect_rd(1, 0, 3, 1, "R7");
    // R6 fetch all setting 0
    send(0, 0, 0, 5);
    send(0, 1, 0, 9);
    send(2, 0, 0, 0);
    expect_rd(1, 1, 0, 9, "R6");
    strobe_stop();
    expect_rd(0, 1, 0, 3, "R6");
    expect_rd(1, 1, 0, 31, "R6");
    // R7 save all into setting 2
    send(0, 0, 0, 12);
    send(0, 1, 0, 50);
    send(4, 1, 2, 0);
    strobe_done();
    expect_rd(0, 0, 2, 12, "R7");
    expect_rd(1, 0, 2, 50, "R7");
    // R2 retention and recall after volatile reset
    send(5, 1, 0, 20);
    strobe_done();
    @(negedge clk); #1; rst_n = 0;
    repeat (2) @(negedge clk); #1; rst_n = 1;
    expect_rd(1, 1, 0, 20, "R2");
    expect_rd(0, 1, 0, 3, "R2");
    expect_rd(0, 0, 1, 33, "R2");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule